// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the configuration header of a root-port bridge as a bank of 32-bit registers. When the `HAS_CAP` parameter is set, it also holds a PCIe capability structure that starts right after the 64-byte standard header. Requests arrive on a valid/ready channel and carry a byte offset, a size of 1, 2 or 4 bytes, a write flag and write data.

Every dword has three attribute masks: read-write, write-one-to-clear and reserved. Any bit that is in none of these masks keeps its value. A narrow write merges only the addressed byte lanes into the stored dword. Reads force reserved bits to zero and then narrow the result to the requested size.

A hardware event port sets write-one-to-clear status bits directly. An illegal size produces an error response and changes nothing. Each accepted request gets one registered response.

Back-pressure works as follows:
- The block accepts a request when `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever no response is waiting, or the waiting response is being taken in that same cycle.
- A response stays on `rsp_valid`, `rsp_rdata` and `rsp_error`, unchanged, until `rsp_ready` is high.

Top module: `bridge_cfg_regfile`

## Requirements
- R1: Reset values:
  - dword 0 is {DEVICE_ID, VENDOR_ID}.
  - dword 1 is 0x0010_0000 (capability-list status bit 20 set).
  - dword 2 is 0x0604_0000 (bridge class code in bits 31:16).
  - dword 3 is 0x0001_0010 (header type 1, cache line size 0x10).
  - With the capability, dword 13 is 0x40 and dword 16 is 0x0142_0010 (ID 0x10, version 2, root port, slot implemented).
  - All other dwords are zero.
- R2: Size codes 1, 2 and 4 are legal.
  - Size 1 uses lane mask 0xFF and size 2 uses 0xFFFF. Both the mask and the data are shifted left by 8 times offset[1:0].
  - Size 4 uses the whole dword and ignores offset[1:0].
  - Any other size returns rsp_error=1 and rdata 0, and changes no register.
- R3: A write replaces the read-write bits inside the lane mask with the shifted write data. Bits outside the lane mask are unchanged. Read-write masks per dword:
  - d1 0x0000_0147, d6 0x00FF_FFFF, d7 0x0000_F0F0, d8 0xFFF0_FFF0, d9 0xFFF0_FFF0.
  - d10, d11 and d12 all ones.
  - d14 0xFFFF_F801, d15 0x0B6F_00FF.
  - d18 0x0000_FFFF, d20 0x0000_0FFB, d22 0x0000_1FFF, d23 0x0000_001F.
  - Every other dword is zero.
- R4: A write clears each write-one-to-clear bit that is inside the lane mask and written as 1. Write-one-to-clear masks:
  - d1 and d7: 0xF900_0000.
  - d15: 0x0400_0000.
  - d18: 0x000F_0000.
  - d20: 0xC000_0000.
  - d22: 0x011F_0000.
  - d24: 0x0001_0000.
- R5: Bits that are neither read-write nor write-one-to-clear are never changed by a write.
- R6: Reads return the stored dword with its reserved bits forced to zero. Sizes 1 and 2 then shift right by 8 times offset[1:0] and mask to 8 or 16 bits. Reserved masks:
  - d1 0x004F_FC00, d7 0x005F_0000, d13 0xFFFF_FF00, d14 0x0000_07FE, d15 0xF010_0000.
  - d18 0xFFE0_0000, d19 0x0080_0000, d20 0x0000_F004, d22 0xFE00_F000, d23 0xFFFE_FFE0, d24 0xFFFC_0000.
- R7: Only dword indices below the implemented count are in range: 16 without the capability, 31 with it (the space ends at offset 0x7C). Out-of-range reads return 0 and out-of-range writes change nothing.
- R8: While `cfg_no_pref` is high, dword 9 (prefetchable base/limit) has no writable bits.
- R9: An event with `evt_valid` sets, in dword `evt_dword`, the bits of `evt_bits` that are write-one-to-clear. If a write clears the same bit in the same cycle, the set wins.
- R10: A response appears one cycle after acceptance. It holds its data until `rsp_ready`, and `req_ready` is low while it waits and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_pref | input | 1 | Makes prefetchable window dword read-only |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | AW | Byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_error | output | 1 | Illegal size |
| evt_valid | input | 1 | Hardware event strobe |
| evt_dword | input | IW | Dword index of the event |
| evt_bits | input | 32 | Status bits to set |

## Verification
A corrupted bit attribute or merge step shows up at the ports on the very next read of that dword. Sweeping every dword with every size and lane offset, and following each write with a full and a narrow read, exposes such a fault within two transactions. A wrong set/clear priority shows as a lost status bit on the read that follows the colliding cycle. A broken hold rule shows as response data that changes while `rsp_ready` is low.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
  localparam int WORD_W     = 32;
  localparam int HDR_DWORDS = 16;
  localparam int CAP_DWORDS = 15;

  typedef struct packed {
    logic [WORD_W-1:0] rw;
    logic [WORD_W-1:0] w1c;
    logic [WORD_W-1:0] rsvd;
  } bit_attr_t;

  function automatic bit_attr_t attr_of(input int idx, input logic no_pref);
    bit_attr_t a;
    a = '0;
    case (idx)
      1:  begin a.rw = 32'h0000_0147; a.w1c = 32'hF900_0000; a.rsvd = 32'h004F_FC00; end
      6:  a.rw = 32'h00FF_FFFF;
      7:  begin a.rw = 32'h0000_F0F0; a.w1c = 32'hF900_0000; a.rsvd = 32'h005F_0000; end
      8:  a.rw = 32'hFFF0_FFF0;
      9:  a.rw = no_pref ? 32'h0 : 32'hFFF0_FFF0;
      10, 11, 12: a.rw = 32'hFFFF_FFFF;
      13: a.rsvd = 32'hFFFF_FF00;
      14: begin a.rw = 32'hFFFF_F801; a.rsvd = 32'h0000_07FE; end
      15: begin a.rw = 32'h0B6F_00FF; a.w1c = 32'h0400_0000; a.rsvd = 32'hF010_0000; end
      18: begin a.rw = 32'h0000_FFFF; a.w1c = 32'h000F_0000; a.rsvd = 32'hFFE0_0000; end
      19: a.rsvd = 32'h0080_0000;
      20: begin a.rw = 32'h0000_0FFB; a.w1c = 32'hC000_0000; a.rsvd = 32'h0000_F004; end
      22: begin a.rw = 32'h0000_1FFF; a.w1c = 32'h011F_0000; a.rsvd = 32'hFE00_F000; end
      23: begin a.rw = 32'h0000_001F; a.rsvd = 32'hFFFE_FFE0; end
      24: begin a.w1c = 32'h0001_0000; a.rsvd = 32'hFFFC_0000; end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [WORD_W-1:0] reset_of(input int idx, input bit has_cap,
                                                 input logic [15:0] vid, input logic [15:0] did);
    case (idx)
      0:  return {did, vid};
      1:  return 32'h0010_0000;
      2:  return 32'h0604_0000;
      3:  return 32'h0001_0010;
      13: return has_cap ? 32'h0000_0040 : 32'h0;
      16: return 32'h0142_0010;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfgrf_attr_table.sv
module cfgrf_attr_table
  import cfgrf_pkg::*;
#(
  parameter int NDW = 31
) (
  input  logic                    no_pref,
  output bit_attr_t [NDW-1:0]     attr
);
  for (genvar i = 0; i < NDW; i++) begin : g_attr
    assign attr[i] = attr_of(i, no_pref);
  end
endmodule

// File: rtl/cfgrf_lane.sv
module cfgrf_lane
  import cfgrf_pkg::*;
(
  input  logic [1:0]        byte_off,
  input  logic [2:0]        size,
  input  logic [WORD_W-1:0] wdata,
  output logic              size_ok,
  output logic [4:0]        shamt,
  output logic [WORD_W-1:0] lane,
  output logic [WORD_W-1:0] wdat_sh
);
  logic [WORD_W-1:0] base;

  always_comb begin
    size_ok = 1'b1;
    shamt   = {byte_off, 3'b000};
    case (size)
      3'd1:    base = 32'h0000_00FF;
      3'd2:    base = 32'h0000_FFFF;
      3'd4:    begin base = 32'hFFFF_FFFF; shamt = 5'd0; end
      default: begin base = '0; size_ok = 1'b0; end
    endcase
    lane    = base << shamt;
    wdat_sh = wdata << shamt;
  end
endmodule

// File: rtl/cfgrf_cell.sv
module cfgrf_cell
  import cfgrf_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rw_m,
  input  logic [WORD_W-1:0] w1c_m,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] lane,
  input  logic [WORD_W-1:0] wdat,
  input  logic [WORD_W-1:0] evt_set,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] wr_rw, wr_clr, nxt;

  always_comb begin
    wr_rw  = lane & rw_m;
    wr_clr = wdat & lane & w1c_m;
    nxt    = q;
    if (wr_en) begin
      nxt = (q & ~wr_rw) | (wdat & wr_rw);
      nxt = nxt & ~wr_clr;
    end
    nxt = nxt | (evt_set & w1c_m);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt;
  end

  AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & w1c_m) != '0) |=> ((q & $past(evt_set & w1c_m)) == $past(evt_set & w1c_m))); // R9

  AST_FIXED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~($past(rw_m) | $past(w1c_m))) == '0)); // R5

  AST_OUTSIDE_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && evt_set == '0) |=> (((q ^ $past(q)) & ~$past(lane)) == '0)); // R3
endmodule

// File: rtl/bridge_cfg_regfile.sv
module bridge_cfg_regfile
  import cfgrf_pkg::*;
#(
  parameter bit          HAS_CAP   = 1'b1,
  parameter int          AW        = 12,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h7A01,
  localparam int         NDW       = HDR_DWORDS + (HAS_CAP ? CAP_DWORDS : 0),
  localparam int         IW        = $clog2(NDW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_no_pref,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_offset,
  input  logic [2:0]        req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_error,
  input  logic              evt_valid,
  input  logic [IW-1:0]     evt_dword,
  input  logic [WORD_W-1:0] evt_bits
);
  bit_attr_t [NDW-1:0]         attr;
  logic [NDW-1:0][WORD_W-1:0]  q_all;
  logic                        fire, size_ok, in_rng, wr_any;
  logic [AW-3:0]               dw_sel;
  logic [IW-1:0]               idx;
  logic [4:0]                  shamt;
  logic [WORD_W-1:0]           lane, wdat_sh, rd_full, rd_sh, rd_out;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign dw_sel    = req_offset[AW-1:2];
  assign in_rng    = 32'(dw_sel) < NDW;
  assign idx       = IW'(dw_sel);
  assign wr_any    = fire && req_write && size_ok && in_rng;

  cfgrf_attr_table #(.NDW(NDW)) u_attr (
    .no_pref (cfg_no_pref),
    .attr    (attr)
  );

  cfgrf_lane u_lane (
    .byte_off (req_offset[1:0]),
    .size     (req_size),
    .wdata    (req_wdata),
    .size_ok  (size_ok),
    .shamt    (shamt),
    .lane     (lane),
    .wdat_sh  (wdat_sh)
  );

  for (genvar i = 0; i < NDW; i++) begin : g_dw
    localparam logic [WORD_W-1:0] RV = reset_of(i, HAS_CAP, VENDOR_ID, DEVICE_ID);
    logic              hit_wr;
    logic [WORD_W-1:0] ev;
    assign hit_wr = wr_any && (idx == IW'(i));
    assign ev     = (evt_valid && evt_dword == IW'(i)) ? evt_bits : '0;
    cfgrf_cell #(.RST_VAL(RV)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .rw_m    (attr[i].rw),
      .w1c_m   (attr[i].w1c),
      .wr_en   (hit_wr),
      .lane    (lane),
      .wdat    (wdat_sh),
      .evt_set (ev),
      .q       (q_all[i])
    );
  end

  always_comb begin
    rd_full = in_rng ? (q_all[idx] & ~attr[idx].rsvd) : '0;
    rd_sh   = rd_full >> shamt;
    case (req_size)
      3'd1:    rd_out = rd_sh & 32'h0000_00FF;
      3'd2:    rd_out = rd_sh & 32'h0000_FFFF;
      3'd4:    rd_out = rd_full;
      default: rd_out = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_error <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_out;
      rsp_error <= !size_ok;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_BAD_SIZE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !size_ok && !evt_valid) |=> $stable(q_all)); // R2

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> (rsp_rdata == '0)); // R2

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && size_ok && !in_rng) |=> (rsp_rdata == '0)); // R7

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && !in_rng && !evt_valid) |=> $stable(q_all)); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_error))); // R10
endmodule

// File: tb/sim_bridge_cfg_regfile.sv
module sim_bridge_cfg_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NDW = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_no_pref = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_offset = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_dword = '0;
  logic [31:0] evt_bits = '0;
  logic        req_ready, rsp_valid, rsp_error;
  logic [31:0] rsp_rdata;

  int errors = 0, checks = 0;
  logic [31:0] mdl [0:NDW-1];
  bit np = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_cfg_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cfg_no_pref(cfg_no_pref),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_error(rsp_error), .evt_valid(evt_valid), .evt_dword(evt_dword),
    .evt_bits(evt_bits)
  );

  function automatic logic [31:0] m_rw(int i);
    case (i)
      1: return 32'h0000_0147;  6: return 32'h00FF_FFFF;  7: return 32'h0000_F0F0;
      8: return 32'hFFF0_FFF0;  9: return np ? 32'h0 : 32'hFFF0_FFF0;
      10, 11, 12: return 32'hFFFF_FFFF;
      14: return 32'hFFFF_F801; 15: return 32'h0B6F_00FF; 18: return 32'h0000_FFFF;
      20: return 32'h0000_0FFB; 22: return 32'h0000_1FFF; 23: return 32'h0000_001F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_w1c(int i);
    case (i)
      1, 7: return 32'hF900_0000; 15: return 32'h0400_0000; 18: return 32'h000F_0000;
      20: return 32'hC000_0000;   22: return 32'h011F_0000; 24: return 32'h0001_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_rsvd(int i);
    case (i)
      1: return 32'h004F_FC00;  7: return 32'h005F_0000;  13: return 32'hFFFF_FF00;
      14: return 32'h0000_07FE; 15: return 32'hF010_0000; 18: return 32'hFFE0_0000;
      19: return 32'h0080_0000; 20: return 32'h0000_F004; 22: return 32'hFE00_F000;
      23: return 32'hFFFE_FFE0; 24: return 32'hFFFC_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int dw, int o, int sz);
    logic [31:0] full;
    full = (dw < NDW) ? (mdl[dw] & ~m_rsvd(dw)) : 32'h0;
    if (sz == 4) return full;
    full = full >> (8 * o);
    return (sz == 1) ? (full & 32'hFF) : (full & 32'hFFFF);
  endfunction

  task automatic mdl_write(int dw, int o, int sz, logic [31:0] d);
    logic [31:0] ln, ds, rw;
    if (dw >= NDW) return;
    ln = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (sz != 4) begin ln = ln << (8 * o); ds = d << (8 * o); end
    else ds = d;
    rw = m_rw(dw) & ln;
    mdl[dw] = (mdl[dw] & ~rw) | (ds & rw);
    mdl[dw] = mdl[dw] & ~(ds & ln & m_w1c(dw));
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(bit w, logic [11:0] off, logic [2:0] sz, logic [31:0] d,
                     bit ev, logic [4:0] evd, logic [31:0] evb,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_offset = off; req_size = sz; req_wdata = d;
    evt_valid = ev; evt_dword = evd; evt_bits = evb;
    @(negedge clk);
    req_valid = 1'b0; evt_valid = 1'b0;
    rd = rsp_rdata; er = rsp_error;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, keep;
    logic er;
    for (int i = 0; i < NDW; i++) mdl[i] = 32'h0;
    mdl[0] = 32'h7A01_C0DE; mdl[1] = 32'h0010_0000; mdl[2] = 32'h0604_0000;
    mdl[3] = 32'h0001_0010; mdl[13] = 32'h40; mdl[16] = 32'h0142_0010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);

    for (int i = 0; i < NDW; i++) begin
      txn(1'b0, 12'(i*4), 3'd4, 0, 0, 0, 0, rd, er);
      chk($sformatf("R1 reset dword %0d", i), rd, mdl[i]);
    end

    for (int dw = 0; dw < 34; dw++)
      for (int k = 0; k < 3; k++)
        for (int o = 0; o < 4; o++) begin
          int sz;
          logic [31:0] d;
          sz = (k == 0) ? 1 : (k == 1) ? 2 : 4;
          d = ((o + k + dw) % 2 == 0) ? 32'hFFFF_FFFF : (32'h5A3C_96E1 ^ (32'(dw) * 32'h0101_0101));
          txn(1'b1, 12'(dw*4 + o), 3'(sz), d, 0, 0, 0, rd, er);
          mdl_write(dw, o, sz, d);
          txn(1'b0, 12'(dw*4), 3'd4, 0, 0, 0, 0, rd, er);
          chk($sformatf("R3 R4 R5 R7 dw%0d sz%0d off%0d full", dw, sz, o), rd, exp_read(dw, 0, 4));
          txn(1'b0, 12'(dw*4 + o), 3'(sz), 0, 0, 0, 0, rd, er);
          chk($sformatf("R6 R2 dw%0d sz%0d off%0d narrow", dw, sz, o), rd, exp_read(dw, o, sz));
        end

    for (int i = 0; i < NDW; i++) begin
      txn(1'b0, 12'h7C, 3'd4, 0, 1'b1, 5'(i), 32'hFFFF_FFFF, rd, er);
      mdl[i] = mdl[i] | m_w1c(i);
      txn(1'b0, 12'(i*4), 3'd4, 0, 0, 0, 0, rd, er);
      chk($sformatf("R9 event dword %0d", i), rd, exp_read(i, 0, 4));
    end

    txn(1'b1, 12'h04, 3'd4, 32'hFFFF_FFFF, 1'b1, 5'd1, 32'h0100_0000, rd, er);
    mdl_write(1, 0, 4, 32'hFFFF_FFFF);
    mdl[1] = mdl[1] | 32'h0100_0000;
    txn(1'b0, 12'h04, 3'd4, 0, 0, 0, 0, rd, er);
    chk("R9 set wins over clear", rd & 32'hF900_0000, 32'h0100_0000);

    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      txn(1'b1, 12'h28, 3'(s), 32'h1234_5678, 0, 0, 0, rd, er);
      chk($sformatf("R2 bad size %0d write error", s), {31'b0, er}, 32'h1);
      txn(1'b0, 12'h28, 3'(s), 0, 0, 0, 0, rd, er);
      chk($sformatf("R2 bad size %0d read data", s), rd, 32'h0);
      txn(1'b0, 12'h28, 3'd4, 0, 0, 0, 0, rd, er);
      chk($sformatf("R2 bad size %0d no change", s), rd, mdl[10]);
    end

    @(negedge clk); cfg_no_pref = 1'b1; np = 1'b1;
    keep = mdl[9];
    txn(1'b1, 12'h24, 3'd4, ~keep, 0, 0, 0, rd, er);
    txn(1'b0, 12'h24, 3'd4, 0, 0, 0, 0, rd, er);
    chk("R8 prefetch window locked", rd, keep);
    @(negedge clk); cfg_no_pref = 1'b0; np = 1'b0;

    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_offset = 12'h00; req_size = 3'd4;
    @(negedge clk);
    req_offset = 12'h08;
    chk("R10 response valid", {31'b0, rsp_valid}, 32'h1);
    chk("R10 ready low while held", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    chk("R10 data held", rsp_rdata, mdl[0]);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next response", rsp_rdata, mdl[2]);
    @(negedge clk);
    chk("R10 response drained", {31'b0, rsp_valid}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule